// File: doc/BRIEF.md
# Character-Synchronous Sync Hunt Receiver

This block sits behind a bit-clock recovery stage and takes one serial bit per `bitValid` strobe. After reset, or whenever the host asks for a re-hunt, it searches the stream one bit at a time for a programmed sync pattern. It moves to the synchronized state on the first bit at which the whole pattern is present. From then on it groups every eight bits into a character and presents each one on `charData` with a one-cycle `charValid` strobe. The sync pattern is taken from two programmed characters. It is either a single short character, a single 8-bit character, two characters received back to back, or one 16-bit word.

Each delivered character waits for one further character time before it reaches the CRC accumulator. The host therefore has that window to decide, through `crcInclude`, whether the character is counted. Two reflected polynomials are available. The register can be preset at any time.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset `inSync` is 0, `charValid` is 0 and `crcValue` is all ones.
- R2: While hunting, the window is compared on each accepted bit (`bitValid` high, `enterHunt` low), with that bit included. A match counts only if at least as many bits as the window length have been accepted since the hunt began. `inSync` rises in the cycle after the first matching bit.
- R3: Monosync (`modeBisync`=0) with `syncLen`=0 (6 bits) or 1 (8 bits): the last 6 or 8 received bits must equal the low 6 bits or all 8 bits of `syncChar2`. Bits arrive LSB first.
- R4: Bisync (`modeBisync`=1) with `syncLen`=0 or 1: a character equal to the low 6 or 8 bits of `syncChar1` must be followed at once by one equal to the same bits of `syncChar2`. Both are LSB first, and the window is 12 or 16 bits.
- R5: With `syncLen`=2 or 3 (16 bits), the pattern is `syncChar1` received first and `syncChar2` second, both LSB first, in either mode.
- R6: Once synchronized, each group of 8 accepted bits is counted from the bit after the matching bit. Each group yields `charData` (first bit in bit 0) with `charValid` high for exactly the cycle after its eighth bit. `charValid` is 0 at all other times, and sync patterns in the data are not hunted.
- R7: `enterHunt` clears `inSync` in the next cycle and discards any bit accepted in the same cycle. Bits received before it do not count toward the next match.
- R8: A delivered character is offered to the CRC at the eighth bit of the next character, while still synchronized. It is accumulated if `crcInclude` is 1 in that cycle, and `crcValue` stays unchanged if it is 0. A re-hunt drops the pending character.
- R9: `crcSel`=0 selects CRC-16 with the reflected polynomial 0xA001, and `crcSel`=1 selects the CCITT polynomial reflected as 0x8408. Character bits are processed LSB first. `crcReset` presets the register to all ones in the next cycle and wins over an update.
- R10: A cycle with `bitValid` low and no `enterHunt` or `crcReset` changes neither `inSync` nor `crcValue`, and raises no `charValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitValid | input | 1 | One recovered bit is present on rxBit |
| rxBit | input | 1 | Serial data bit |
| modeBisync | input | 1 | 0: one sync character, 1: two back to back |
| syncLen | input | 2 | 0: 6 bits, 1: 8 bits, 2/3: 16 bits |
| syncChar1 | input | 8 | First programmed sync character |
| syncChar2 | input | 8 | Second programmed sync character (monosync pattern) |
| enterHunt | input | 1 | Drop sync and restart the search |
| crcSel | input | 1 | 0: CRC-16, 1: CCITT polynomial |
| crcReset | input | 1 | Preset the CRC to all ones |
| crcInclude | input | 1 | Include the delayed character in the CRC |
| inSync | output | 1 | Character alignment found |
| charData | output | 8 | Assembled character |
| charValid | output | 1 | charData holds a new character this cycle |
| crcValue | output | 16 | Current CRC register |

## Verification
The bench uses the default 8-bit character and 16-bit CRC. At these sizes the whole hunt window fits in one 16-bit history, so a bench model can follow every bit. The bench sweeps all six mode and length combinations under both polynomials, with random leading noise, back-to-back data and alternating include decisions. These sizes make every alignment outcome reachable in a short run. That covers noise that matches early, a mid-character re-hunt with a discarded bit, and a dropped pending character.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
  typedef struct packed {
    logic shiftEn;
    logic clearHist;
    logic charDone;
    logic commit;
  } ctrlStrobesT;
endpackage

// File: rtl/sync_hunt_ctrl.sv
module sync_hunt_ctrl
  import sync_hunt_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitValid,
  input  logic        enterHunt,
  input  logic        modeBisync,
  input  logic [1:0]  syncLen,
  input  logic        patternMatch,
  output ctrlStrobesT strobes,
  output logic        inSync
);
  localparam int HIST_W  = 2 * CHAR_W;
  localparam int SHORT_W = CHAR_W - 2;
  localparam int FILL_W  = $clog2(HIST_W + 1);
  localparam int CNT_W   = $clog2(CHAR_W);

  logic [FILL_W-1:0] fillCnt, fillNext, winLen;
  logic [CNT_W-1:0]  bitCnt;
  logic              pendValid, lastBit, accept, huntHit;

  always_comb begin
    case (syncLen)
      2'd0:    winLen = modeBisync ? FILL_W'(2 * SHORT_W) : FILL_W'(SHORT_W);
      2'd1:    winLen = modeBisync ? FILL_W'(HIST_W) : FILL_W'(CHAR_W);
      default: winLen = FILL_W'(HIST_W);
    endcase
  end

  always_comb begin
    fillNext = (fillCnt == FILL_W'(HIST_W)) ? fillCnt : fillCnt + 1'b1;
    lastBit  = (bitCnt == CNT_W'(CHAR_W - 1));
    accept   = bitValid && !enterHunt;
    huntHit  = accept && !inSync && patternMatch && (fillNext >= winLen);
    strobes.shiftEn   = accept;
    strobes.clearHist = enterHunt;
    strobes.charDone  = accept && inSync && lastBit;
    strobes.commit    = accept && inSync && lastBit && pendValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSync    <= 1'b0;
      fillCnt   <= '0;
      bitCnt    <= '0;
      pendValid <= 1'b0;
    end else if (enterHunt) begin
      inSync    <= 1'b0;
      fillCnt   <= '0;
      bitCnt    <= '0;
      pendValid <= 1'b0;
    end else if (bitValid) begin
      if (!inSync) begin
        fillCnt <= fillNext;
        if (huntHit) begin
          inSync <= 1'b1;
          bitCnt <= '0;
        end
      end else begin
        bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
        if (lastBit) pendValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_hunt_dp.sv
module sync_hunt_dp
  import sync_hunt_pkg::*;
#(
  parameter int          CHAR_W     = 8,
  parameter int          CRC_W      = 16,
  parameter logic [15:0] POLY_CRC16 = 16'hA001,
  parameter logic [15:0] POLY_CCITT = 16'h8408
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxBit,
  input  logic              modeBisync,
  input  logic [1:0]        syncLen,
  input  logic [CHAR_W-1:0] syncChar1,
  input  logic [CHAR_W-1:0] syncChar2,
  input  logic              crcSel,
  input  logic              crcReset,
  input  logic              crcInclude,
  input  ctrlStrobesT       strobes,
  output logic              patternMatch,
  output logic [CHAR_W-1:0] charData,
  output logic              charValid,
  output logic [CRC_W-1:0]  crcValue
);
  localparam int HIST_W  = 2 * CHAR_W;
  localparam int SHORT_W = CHAR_W - 2;

  logic [HIST_W-1:0] hist, nextHist;
  logic [CHAR_W-1:0] pendChar, newChar;
  logic [CRC_W-1:0]  poly, crcNext;
  logic winShort, winChar, winLong, winBiShort;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c,
                                               input logic [CHAR_W-1:0] d,
                                               input logic [CRC_W-1:0] p);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < CHAR_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ p;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_comb begin
    nextHist   = {rxBit, hist[HIST_W-1:1]};
    newChar    = nextHist[HIST_W-1 -: CHAR_W];
    winShort   = nextHist[HIST_W-1 -: SHORT_W] == syncChar2[SHORT_W-1:0];
    winChar    = newChar == syncChar2;
    winLong    = nextHist == {syncChar2, syncChar1};
    winBiShort = nextHist[HIST_W-1 -: 2*SHORT_W] ==
                 {syncChar2[SHORT_W-1:0], syncChar1[SHORT_W-1:0]};
    case (syncLen)
      2'd0:    patternMatch = modeBisync ? winBiShort : winShort;
      2'd1:    patternMatch = modeBisync ? winLong : winChar;
      default: patternMatch = winLong;
    endcase
    poly    = crcSel ? CRC_W'(POLY_CCITT) : CRC_W'(POLY_CRC16);
    crcNext = crcStep(crcValue, pendChar, poly);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist      <= '0;
      pendChar  <= '0;
      charData  <= '0;
      charValid <= 1'b0;
      crcValue  <= '1;
    end else begin
      if (strobes.clearHist)    hist <= '0;
      else if (strobes.shiftEn) hist <= nextHist;
      charValid <= strobes.charDone;
      if (strobes.charDone) begin
        charData <= newChar;
        pendChar <= newChar;
      end
      if (crcReset)                             crcValue <= '1;
      else if (strobes.commit && crcInclude)    crcValue <= crcNext;
    end
  end
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
  import sync_hunt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitValid,
  input  logic        rxBit,
  input  logic        modeBisync,
  input  logic [1:0]  syncLen,
  input  logic [7:0]  syncChar1,
  input  logic [7:0]  syncChar2,
  input  logic        enterHunt,
  input  logic        crcSel,
  input  logic        crcReset,
  input  logic        crcInclude,
  output logic        inSync,
  output logic [7:0]  charData,
  output logic        charValid,
  output logic [15:0] crcValue
);
  ctrlStrobesT strobes;
  logic        patternMatch;

  sync_hunt_ctrl #(.CHAR_W(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .enterHunt(enterHunt),
    .modeBisync(modeBisync), .syncLen(syncLen), .patternMatch(patternMatch),
    .strobes(strobes), .inSync(inSync)
  );

  sync_hunt_dp #(.CHAR_W(8), .CRC_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .modeBisync(modeBisync),
    .syncLen(syncLen), .syncChar1(syncChar1), .syncChar2(syncChar2),
    .crcSel(crcSel), .crcReset(crcReset), .crcInclude(crcInclude),
    .strobes(strobes), .patternMatch(patternMatch), .charData(charData),
    .charValid(charValid), .crcValue(crcValue)
  );
endmodule

// File: rtl/sync_hunt_chk.sv
module sync_hunt_chk (
  input logic        clk,
  input logic        rstN,
  input logic        bitValid,
  input logic        enterHunt,
  input logic        crcReset,
  input logic        inSync,
  input logic        charValid,
  input logic [15:0] crcValue
);
  p_sync_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSync) |-> $past(bitValid && !enterHunt));

  p_drop_on_hunt_r7: assert property (@(posedge clk) disable iff (!rstN)
    enterHunt |=> !inSync);

  p_valid_needs_sync_r6: assert property (@(posedge clk) disable iff (!rstN)
    charValid |-> $past(inSync && bitValid && !enterHunt));

  p_no_valid_hunting_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inSync |=> !charValid);

  p_crc_preset_r9: assert property (@(posedge clk) disable iff (!rstN)
    crcReset |=> (crcValue == 16'hFFFF));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !enterHunt && !crcReset) |=> ($stable(crcValue) && $stable(inSync)));
endmodule

bind sync_hunt_rx sync_hunt_chk u_chk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .enterHunt(enterHunt),
  .crcReset(crcReset), .inSync(inSync), .charValid(charValid),
  .crcValue(crcValue)
);

// File: tb/sim_sync_hunt_rx.sv
module sim_sync_hunt_rx;
  logic clk = 1'b0, rstN = 1'b0;
  logic bitValid = 0, rxBit = 0, modeBisync = 0, enterHunt = 0;
  logic crcSel = 0, crcReset = 0, crcInclude = 0;
  logic [1:0] syncLen = 0;
  logic [7:0] syncChar1 = 0, syncChar2 = 0;
  logic inSync, charValid;
  logic [7:0] charData;
  logic [15:0] crcValue;

  int nChecks = 0, nFails = 0;
  string syncTag = "R3";

  // bench model state
  bit mSync, mPend, expValid;
  bit [15:0] mHist, mCrc;
  bit [7:0] mPendChar, expData;
  int mFill, mCnt;

  sync_hunt_rx u0 (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxBit(rxBit),
    .modeBisync(modeBisync), .syncLen(syncLen), .syncChar1(syncChar1),
    .syncChar2(syncChar2), .enterHunt(enterHunt), .crcSel(crcSel),
    .crcReset(crcReset), .crcInclude(crcInclude), .inSync(inSync),
    .charData(charData), .charValid(charValid), .crcValue(crcValue)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [15:0] refCrc(input bit [15:0] c, input bit [7:0] d, input bit sel);
    bit [15:0] p = sel ? 16'h8408 : 16'hA001;
    for (int i = 0; i < 8; i++) c = ((c[0] ^ d[i]) != 0) ? ((c >> 1) ^ p) : (c >> 1);
    return c;
  endfunction

  function automatic int winLength();
    if (syncLen >= 2) return 16;
    if (syncLen == 1) return modeBisync ? 16 : 8;
    return modeBisync ? 12 : 6;
  endfunction

  function automatic bit refMatch(input bit [15:0] h);
    if (syncLen >= 2 || (syncLen == 1 && modeBisync)) return h == {syncChar2, syncChar1};
    if (syncLen == 1) return h[15:8] == syncChar2;
    if (modeBisync) return h[15:4] == {syncChar2[5:0], syncChar1[5:0]};
    return h[15:10] == syncChar2[5:0];
  endfunction

  task automatic modelStep(input bit bv, input bit b, input bit eh, input bit cr, input bit inc);
    bit [15:0] nb;
    expValid = 0;
    if (eh) begin
      mSync = 0; mFill = 0; mHist = 0; mPend = 0; mCnt = 0;
    end else if (bv) begin
      nb = {b, mHist[15:1]};
      if (!mSync) begin
        if (mFill < 16) mFill++;
        if (mFill >= winLength() && refMatch(nb)) begin mSync = 1; mCnt = 0; end
      end else if (mCnt == 7) begin
        expValid = 1; expData = nb[15:8];
        if (mPend && inc) mCrc = refCrc(mCrc, mPendChar, crcSel);
        mPendChar = nb[15:8]; mPend = 1; mCnt = 0;
      end else mCnt++;
      mHist = nb;
    end
    if (cr) mCrc = 16'hFFFF;
  endtask

  task automatic step(input bit bv, input bit b, input bit eh, input bit cr, input bit inc);
    bitValid = bv; rxBit = b; enterHunt = eh; crcReset = cr; crcInclude = inc;
    modelStep(bv, b, eh, cr, inc);
    @(posedge clk);
    @(negedge clk);
    bitValid = 0; enterHunt = 0; crcReset = 0;
    chk(inSync == mSync, eh ? "R7 inSync" : (bv ? {syncTag, " inSync"} : "R10 inSync"),
        int'(inSync), int'(mSync));
    chk(charValid == expValid && (!expValid || charData == expData),
        bv ? "R6 char" : "R10 char", {charValid, charData}, {expValid, expData});
    chk(crcValue == mCrc, cr ? "R9 crc" : "R8 crc", crcValue, mCrc);
  endtask

  task automatic sendChar(input bit [7:0] v, input int n, input bit inc);
    for (int i = 0; i < n; i++) step(1, v[i], 0, 0, inc);
  endtask

  task automatic sendPattern();
    int l = (syncLen == 0) ? 6 : 8;
    if (syncLen >= 2 || modeBisync) sendChar(syncChar1, l, 0);
    sendChar(syncChar2, l, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    mSync = 0; mPend = 0; mHist = 0; mCrc = 16'hFFFF; mFill = 0; mCnt = 0;
    repeat (3) @(negedge clk);
    chk(inSync == 0, "R1 inSync", int'(inSync), 0);
    chk(charValid == 0, "R1 charValid", int'(charValid), 0);
    chk(crcValue == 16'hFFFF, "R1 crc", crcValue, 16'hFFFF);
    rstN = 1;
    @(negedge clk);
    for (int cs = 0; cs < 2; cs++) begin
      for (int c = 0; c < 6; c++) begin
        crcSel = cs[0];
        modeBisync = (c >= 3);
        syncLen = 2'(c % 3);
        syncTag = (syncLen == 2) ? "R5" : (modeBisync ? "R4" : "R3");
        syncChar1 = 8'(8'h16 + c * 37 + cs * 11);
        syncChar2 = 8'(8'h96 ^ (c * 53 + cs * 5));
        step(0, 0, 1, 1, 0);
        for (int i = 0; i < 20; i++) step(1, 1'($urandom % 2), 0, 0, 0);
        sendPattern();
        for (int k = 0; k < 6; k++) begin
          sendChar(8'(c * 53 + k * 29 + cs * 7), 8, k[0] ^ cs[0]);
          step(0, 0, 0, 0, 0);
        end
        sendChar(8'h5A, 3, 1);
        step(1, 1, 1, 0, 1);
        sendChar(8'hC3, 5, 1);
        sendPattern();
        sendChar(8'(c * 17 + 3), 8, 1);
        sendChar(8'(c * 71 + 9), 8, 1);
        step(0, 0, 0, 1, 0);
        sendChar(8'hE7, 8, 1);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule